// File: doc/BRIEF.md
# Back-to-Back Instruction Dependency Detector

This block looks at two instructions that issue in consecutive cycles, an older one and the younger one that follows it, and decides whether the younger one must wait for the older one. Decoding happens upstream. The block receives operand descriptors that are already classified:

- the kind and register number of the older instruction's destination;
- the kind and register number of each source slot of the younger instruction;
- the younger instruction's own destination descriptor, because a memory-form destination carries a base register that is really a read;
- one bit saying the older instruction writes the condition flag, and one saying the younger instruction reads it.

The dependency verdict is combinational and valid in the same cycle as the inputs, so an issue stage can use it directly as a stall term. A saturating counter records how many cycles presented a valid pair that was judged dependent. Forwarding is not modelled: every conflict the rules find is reported as a dependency.

Top module: `pair_hazard_detect`

## Requirements
- R1: When `pairValid` is high, `oldFlagWr` is high and `newFlagRd` is high, `depOut` is 1 whatever the operand descriptors hold, including when the older instruction has no destination.
- R2: A source slot whose kind code is 0 (immediate) or 3 (reserved, treated as immediate) never causes a dependency, even when its register field equals the older destination register.
- R3: When the older destination kind is 1 (direct register) and a source slot has kind 1 (direct register), that slot conflicts exactly when the two register numbers are equal.
- R4: When the older destination kind is 2 (memory address formed from base plus displacement), a source slot of kind 1 (direct register) never conflicts, whatever its register number.
- R5: When the older destination kind is 1 and a source slot has kind 2 (displacement base register), that slot conflicts exactly when its base register number equals the older destination register.
- R6: When the older destination kind is 2 and a source slot has kind 2, the slot always conflicts, because a memory write must complete before a later memory access. The register numbers do not matter.
- R7: When the older destination kind is 0 (none) or 3 (reserved, treated as none), no register or memory conflict is reported, and `depOut` follows R1 alone.
- R8: When the younger destination kind is 2, its base register `newDstReg` is checked as an extra source of kind 2 under R5 and R6. A younger destination of kind 1 is never checked as a source.
- R9: Source slot i takes its kind from `newSrcKind[2i+1:2i]` and its register number from `newSrcReg[5i+4:5i]`. All slots are judged in parallel, and `depOut` is the OR of every slot verdict and the flag rule.
- R10: `depOut` is 0 whenever `pairValid` is 0, and it responds to its inputs in the same cycle with no register in the path.
- R11: `hazardCount` increases by exactly 1 at the rising edge that ends a cycle in which `pairValid` and `depOut` are both 1. Otherwise it holds its value.
- R12: `hazardCount` saturates at 65535 and stays there while further dependent pairs arrive.
- R13: `hazardCount` clears to 0 at any rising edge where `rst` is high. A reset overrides an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pairValid | input | 1 | The two descriptor sets form a real consecutive pair |
| oldDstKind | input | 2 | Older destination kind: 0 none, 1 register, 2 memory displacement, 3 none |
| oldDstReg | input | 5 | Older destination register, or base register for kind 2 |
| oldFlagWr | input | 1 | Older instruction writes the condition flag |
| newSrcKind | input | 6 | Kind of each of the three younger source slots, 2 bits per slot: 0 immediate, 1 register, 2 displacement base, 3 immediate |
| newSrcReg | input | 15 | Register number of each of the three younger source slots, 5 bits per slot |
| newDstKind | input | 2 | Younger destination kind, same coding as oldDstKind |
| newDstReg | input | 5 | Younger destination register, or base register for kind 2 |
| newFlagRd | input | 1 | Younger instruction reads the condition flag |
| depOut | output | 1 | Younger instruction depends on the older one |
| hazardCount | output | 16 | Saturating count of cycles with a dependent valid pair |

## Verification
The dependency verdict is combinational. The bench therefore drives each pair just after a falling edge and compares `depOut` a few nanoseconds later, before the next rising edge. The counter has a single register stage. Its expected value is advanced in the bench only at the rising edge that closes a dependent valid cycle, and it is compared one nanosecond after that edge. The reset and saturation cases use the same one-edge lag, so the count is checked at the edge where reset wins over an increment and at the edges around the ceiling.

// File: rtl/hazdet_pkg.sv
package hazdet_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_REG  = 2'd1,
    DST_MEM  = 2'd2,
    DST_RSVD = 2'd3
  } dstKind_e;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_REG  = 2'd1,
    SRC_BASE = 2'd2,
    SRC_RSVD = 2'd3
  } srcKind_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic countClr;
    logic countInc;
  } ctlStrobe_t;

endpackage

// File: rtl/hazdet_datapath.sv
module hazdet_datapath
  import hazdet_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int REG_W   = 5,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic [1:0]               oldDstKind,
  input  logic [REG_W-1:0]         oldDstReg,
  input  logic [NUM_SRC*2-1:0]     newSrcKind,
  input  logic [NUM_SRC*REG_W-1:0] newSrcReg,
  input  logic [1:0]               newDstKind,
  input  logic [REG_W-1:0]         newDstReg,
  input  ctlStrobe_t               strobe,
  output logic [NUM_SRC:0]         slotHit,
  output logic                     cntFull,
  output logic [CNT_W-1:0]         hazardCount
);

  localparam int NUM_SLOT = NUM_SRC + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  dstKind_e olderKind;
  dstKind_e youngerKind;

  assign olderKind   = dstKind_e'(oldDstKind);
  assign youngerKind = dstKind_e'(newDstKind);

  // One comparator per read slot; the last slot is the younger memory base
  for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
    srcKind_e         kind;
    logic [REG_W-1:0] regNum;
    logic             hit;

    if (g < NUM_SRC) begin : gPlain
      assign kind   = srcKind_e'(newSrcKind[g*2 +: 2]);
      assign regNum = newSrcReg[g*REG_W +: REG_W];
    end else begin : gStoreBase
      assign kind   = (youngerKind == DST_MEM) ? SRC_BASE : SRC_IMM;
      assign regNum = newDstReg;
    end

    always_comb begin
      case (olderKind)
        DST_REG: hit = ((kind == SRC_REG) || (kind == SRC_BASE)) &&
                       (regNum == oldDstReg);
        DST_MEM: hit = (kind == SRC_BASE);
        default: hit = 1'b0;
      endcase
    end

    assign slotHit[g] = hit;
  end

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (strobe.countClr) begin
      countQ <= '0;
    end else if (strobe.countInc) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign cntFull     = (countQ == CNT_MAX);
  assign hazardCount = countQ;

endmodule

// File: rtl/hazdet_control.sv
module hazdet_control
  import hazdet_pkg::*;
#(
  parameter int NUM_SLOT = 4
) (
  input  logic                rst,
  input  logic                pairValid,
  input  logic                oldFlagWr,
  input  logic                newFlagRd,
  input  logic [NUM_SLOT-1:0] slotHit,
  input  logic                cntFull,
  output logic                depOut,
  output ctlStrobe_t          strobe
);

  logic flagHit;
  logic anySlot;

  assign flagHit = oldFlagWr & newFlagRd;
  assign anySlot = |slotHit;
  assign depOut  = pairValid & (flagHit | anySlot);

  always_comb begin
    strobe.countClr = rst;
    strobe.countInc = depOut & ~cntFull & ~rst;
  end

endmodule

// File: rtl/pair_hazard_detect.sv
module pair_hazard_detect
  import hazdet_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int REG_W   = 5,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pairValid,
  input  logic [1:0]               oldDstKind,
  input  logic [REG_W-1:0]         oldDstReg,
  input  logic                     oldFlagWr,
  input  logic [NUM_SRC*2-1:0]     newSrcKind,
  input  logic [NUM_SRC*REG_W-1:0] newSrcReg,
  input  logic [1:0]               newDstKind,
  input  logic [REG_W-1:0]         newDstReg,
  input  logic                     newFlagRd,
  output logic                     depOut,
  output logic [CNT_W-1:0]         hazardCount
);

  localparam int NUM_SLOT = NUM_SRC + 1;

  logic [NUM_SLOT-1:0] slotHit;
  logic                cntFull;
  ctlStrobe_t          strobe;

  hazdet_datapath #(
    .NUM_SRC(NUM_SRC),
    .REG_W  (REG_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .oldDstKind (oldDstKind),
    .oldDstReg  (oldDstReg),
    .newSrcKind (newSrcKind),
    .newSrcReg  (newSrcReg),
    .newDstKind (newDstKind),
    .newDstReg  (newDstReg),
    .strobe     (strobe),
    .slotHit    (slotHit),
    .cntFull    (cntFull),
    .hazardCount(hazardCount)
  );

  hazdet_control #(
    .NUM_SLOT(NUM_SLOT)
  ) u_ctl (
    .rst      (rst),
    .pairValid(pairValid),
    .oldFlagWr(oldFlagWr),
    .newFlagRd(newFlagRd),
    .slotHit  (slotHit),
    .cntFull  (cntFull),
    .depOut   (depOut),
    .strobe   (strobe)
  );

endmodule

// File: rtl/pair_hazard_detect_chk.sv
module pair_hazard_detect_chk #(
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pairValid,
  input logic [1:0]           oldDstKind,
  input logic                 oldFlagWr,
  input logic [NUM_SRC*2-1:0] newSrcKind,
  input logic [1:0]           newDstKind,
  input logic                 newFlagRd,
  input logic                 depOut,
  input logic [CNT_W-1:0]     hazardCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic flagPair;
  logic anyRead;

  assign flagPair = oldFlagWr & newFlagRd;

  always_comb begin
    anyRead = (newDstKind == 2'd2);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (newSrcKind[i*2 +: 2] == 2'd1 || newSrcKind[i*2 +: 2] == 2'd2) begin
        anyRead = 1'b1;
      end
    end
  end

  assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !pairValid |-> !depOut);

  assert_flag_R1: assert property (@(posedge clk) disable iff (rst)
    pairValid && flagPair |-> depOut);

  assert_no_dest_R7: assert property (@(posedge clk) disable iff (rst)
    pairValid && !flagPair && (oldDstKind == 2'd0 || oldDstKind == 2'd3)
    |-> !depOut);

  assert_imm_only_R2: assert property (@(posedge clk) disable iff (rst)
    pairValid && !flagPair && !anyRead |-> !depOut);

  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    pairValid && depOut && hazardCount != CNT_MAX
    |=> hazardCount == CNT_W'($past(hazardCount) + 1'b1));

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(pairValid && depOut) |=> $stable(hazardCount));

  assert_saturate_R12: assert property (@(posedge clk) disable iff (rst)
    hazardCount == CNT_MAX |=> hazardCount == CNT_MAX);

  assert_clear_R13: assert property (@(posedge clk)
    rst |=> hazardCount == '0);

endmodule

bind pair_hazard_detect pair_hazard_detect_chk #(
  .NUM_SRC(NUM_SRC),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pairValid  (pairValid),
  .oldDstKind (oldDstKind),
  .oldFlagWr  (oldFlagWr),
  .newSrcKind (newSrcKind),
  .newDstKind (newDstKind),
  .newFlagRd  (newFlagRd),
  .depOut     (depOut),
  .hazardCount(hazardCount)
);

// File: tb/sim_pair_hazard_detect.sv
`timescale 1ns/1ps
module sim_pair_hazard_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pairValid = 1'b0;
  logic [1:0]  oDk = 2'd0;
  logic [4:0]  oDr = 5'd0;
  logic        oFw = 1'b0;
  logic [1:0]  sK0 = 2'd0, sK1 = 2'd0, sK2 = 2'd0;
  logic [4:0]  sR0 = 5'd0, sR1 = 5'd0, sR2 = 5'd0;
  logic [1:0]  nDk = 2'd0;
  logic [4:0]  nDr = 5'd0;
  logic        nFr = 1'b0;
  logic        depOut;
  logic [15:0] hazardCount;

  int compared = 0;
  int mismatched = 0;
  int expCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pair_hazard_detect u0 (
    .clk        (clk),
    .rst        (rst),
    .pairValid  (pairValid),
    .oldDstKind (oDk),
    .oldDstReg  (oDr),
    .oldFlagWr  (oFw),
    .newSrcKind ({sK2, sK1, sK0}),
    .newSrcReg  ({sR2, sR1, sR0}),
    .newDstKind (nDk),
    .newDstReg  (nDr),
    .newFlagRd  (nFr),
    .depOut     (depOut),
    .hazardCount(hazardCount)
  );

  function automatic bit refSlot(logic [1:0] dk, logic [4:0] dr,
                                 logic [1:0] sk, logic [4:0] sr);
    if (sk == 2'd0 || sk == 2'd3) return 1'b0;
    if (dk == 2'd1) return (sr == dr);
    if (dk == 2'd2) return (sk == 2'd2);
    return 1'b0;
  endfunction

  function automatic bit refDep();
    bit d;
    if (!pairValid) return 1'b0;
    d = oFw && nFr;
    d |= refSlot(oDk, oDr, sK0, sR0);
    d |= refSlot(oDk, oDr, sK1, sR1);
    d |= refSlot(oDk, oDr, sK2, sR2);
    if (nDk == 2'd2) d |= refSlot(oDk, oDr, 2'd2, nDr);
    return d;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setPair(logic v, logic [1:0] dk, logic [4:0] dr, logic fw,
                         logic fr, logic [1:0] ndk, logic [4:0] ndr,
                         logic [1:0] k0, logic [4:0] r0,
                         logic [1:0] k1, logic [4:0] r1,
                         logic [1:0] k2, logic [4:0] r2);
    pairValid = v; oDk = dk; oDr = dr; oFw = fw; nFr = fr;
    nDk = ndk; nDr = ndr;
    sK0 = k0; sR0 = r0; sK1 = k1; sR1 = r1; sK2 = k2; sR2 = r2;
  endtask

  // Called just after a falling edge with inputs set; returns after the next falling edge
  task automatic step(string req, int expDep);
    bit d;
    #3;
    d = refDep();
    check({req, " dep model"}, d, expDep);
    check({req, " depOut"}, depOut, expDep);
    if (d && expCnt < 65535) expCnt++;
    @(posedge clk);
    #1;
    check({req, " count"}, hazardCount, expCnt);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R13 reset count", hazardCount, 0);

    // R1: flag hazard with no destination
    setPair(1, 2'd0, 5'd0, 1, 1, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R1", 1);
    // R2: immediate field equal to destination register
    setPair(1, 2'd1, 5'd5, 0, 0, 2'd0, 5'd0, 2'd0, 5'd5, 2'd3, 5'd5, 2'd0, 5'd5);
    step("R2", 0);
    // R3: register vs register, equal then different
    setPair(1, 2'd1, 5'd5, 0, 0, 2'd0, 5'd0, 2'd1, 5'd5, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R3 equal", 1);
    setPair(1, 2'd1, 5'd5, 0, 0, 2'd0, 5'd0, 2'd1, 5'd6, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R3 differ", 0);
    // R4: memory destination vs register source with same number
    setPair(1, 2'd2, 5'd5, 0, 0, 2'd0, 5'd0, 2'd1, 5'd5, 2'd1, 5'd5, 2'd1, 5'd5);
    step("R4", 0);
    // R5: register destination vs displacement base
    setPair(1, 2'd1, 5'd7, 0, 0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd2, 5'd7, 2'd0, 5'd0);
    step("R5 match", 1);
    setPair(1, 2'd1, 5'd7, 0, 0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd2, 5'd3, 2'd0, 5'd0);
    step("R5 differ", 0);
    // R6: memory vs memory, different bases
    setPair(1, 2'd2, 5'd2, 0, 0, 2'd0, 5'd0, 2'd2, 5'd9, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R6", 1);
    // R7: no destination, reserved destination
    setPair(1, 2'd0, 5'd0, 1, 0, 2'd2, 5'd0, 2'd1, 5'd0, 2'd2, 5'd0, 2'd1, 5'd0);
    step("R7 none", 0);
    setPair(1, 2'd3, 5'd4, 0, 1, 2'd0, 5'd0, 2'd1, 5'd4, 2'd2, 5'd4, 2'd0, 5'd0);
    step("R7 reserved", 0);
    // R8: younger store base checked as a read
    setPair(1, 2'd1, 5'd4, 0, 0, 2'd2, 5'd4, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R8 base", 1);
    setPair(1, 2'd1, 5'd4, 0, 0, 2'd1, 5'd4, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R8 reg dest", 0);
    setPair(1, 2'd2, 5'd1, 0, 0, 2'd2, 5'd8, 2'd0, 5'd0, 2'd1, 5'd1, 2'd0, 5'd0);
    step("R8 mem-mem", 1);
    // R9: only the last slot matches
    setPair(1, 2'd1, 5'd12, 0, 0, 2'd0, 5'd0, 2'd1, 5'd1, 2'd1, 5'd2, 2'd1, 5'd12);
    step("R9 slot2", 1);
    // R10: invalid pair hides a flag and register hazard
    setPair(0, 2'd1, 5'd3, 1, 1, 2'd0, 5'd0, 2'd1, 5'd3, 2'd0, 5'd0, 2'd0, 5'd0);
    step("R10", 0);

    // R9 R11: random pairs over a small register range to force matches
    for (int i = 0; i < 3000; i++) begin
      setPair($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
              5'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
              $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
              5'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
      step("R9 R11 random", int'(refDep()));
    end

    // R13: reset wins over a same-cycle increment
    setPair(1, 2'd0, 5'd0, 1, 1, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    expCnt = 0;
    check("R13 reset over inc", hazardCount, 0);
    @(negedge clk);
    rst = 1'b0;

    // R12: drive to the ceiling
    for (int i = 0; i < 65534; i++) begin
      @(posedge clk);
      expCnt++;
    end
    #1;
    check("R12 below max", hazardCount, 65534);
    @(negedge clk);
    step("R12 reach max", 1);
    for (int i = 0; i < 4; i++) step("R12 hold max", 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule